// File: doc/BRIEF.md
# Subcarrier-to-Line Fractional Divider

This block divides the colour subcarrier clock down to a line-rate reference pulse. The ratio between the two rates is not a whole number, and it differs for each supported television standard. Line periods are therefore measured in whole subcarrier cycles. A fraction accumulator adds one extra cycle to selected lines, so that the average period matches the exact ratio. The accumulator works in units of 1/2500 of a cycle, which is enough to express a quarter-line offset combined with a 1/625 correction.

The reference pulse goes to a three-state phase comparator. The comparator also receives the line pulse generated elsewhere on the chip. It raises an "advance" flag when the reference arrives first and a "retard" flag when the line pulse arrives first, and it goes idle once both have been seen. An external loop filter and oscillator use these flags to hold the line rate at the exact ratio to the subcarrier. The whole block runs on the subcarrier clock and has a synchronous active-high reset.

Top module: `sc_line_divider`

## Requirements
- R1: While reset is high, and immediately after it, `ref_pulse`, `pd_up` and `pd_dn` are 0. The first reference pulse is high for the one cycle that follows the first rising edge with reset low.
- R2: Number the reference pulses k = 0, 1, 2, ... from reset, and let the ratio for the selected standard be I + F/2500. Pulse k occurs exactly k·I + floor(k·F/2500) cycles after pulse 0. Every interval is therefore I or I+1 cycles long.
- R3: The standard select codes map to these ratios: 0 → 283 + 1879/2500, 1 → 229 + 629/2500, 2 → 227 + 1250/2500, 3 → 227 + 625/2500, 4 → 282 + 0/2500. Codes 5, 6 and 7 behave like code 0.
- R4: The standard select is read only in the cycle in which a new period starts. A change in the middle of a period leaves that period's length unchanged, and the next period uses the new ratio.
- R5: Each reference pulse lasts exactly one cycle.
- R6: Suppose a reference pulse arrives while the comparator is idle and no line pulse arrives in the same cycle. Then `pd_up` goes high on the following edge and stays high until a line pulse arrives.
- R7: Suppose a line pulse arrives while the comparator is idle and no reference pulse arrives in the same cycle. Then `pd_dn` goes high on the following edge and stays high until a reference pulse arrives.
- R8: If a line pulse arrives while `pd_up` is high, or a reference pulse arrives while `pd_dn` is high, both flags are 0 after the next edge.
- R9: If a reference pulse and a line pulse arrive in the same cycle while the comparator is idle, both flags stay 0.
- R10: `pd_up` and `pd_dn` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subcarrier clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 3 | Television standard code (see R3) |
| line_pulse | input | 1 | Internal line pulse, one cycle wide |
| ref_pulse | output | 1 | Divided line-rate reference, one cycle wide |
| pd_up | output | 1 | Reference leads the line pulse |
| pd_dn | output | 1 | Line pulse leads the reference |

## Verification
The comparator can see a reference pulse and a line pulse in the same cycle. That case must leave it idle rather than raise either flag. The bench provokes it by predicting each reference cycle and driving the line pulse in exactly that cycle. It also runs lagging, leading and free-running line patterns. A behavioural model checks both flags on every clock against the observed pulses. In a separate run, the standard changes in the middle of a period, and the intervals on each side of the next period start are judged against the old and the new ratio.

// File: rtl/sc_div_pkg.sv
package sc_div_pkg;

  typedef enum logic [2:0] {
    STD_PAL_BG = 3'd0,
    STD_PAL_N  = 3'd1,
    STD_NTSC   = 3'd2,
    STD_PAL_M  = 3'd3,
    STD_SECAM  = 3'd4
  } tv_std_e;

  // Fraction denominator: 4 quarters x 625 lines
  localparam int FRAC_DEN = 2500;

  localparam int BG_INT    = 283;
  localparam int BG_FRAC   = 1879;  // 0.75 + 1/625
  localparam int N_INT     = 229;
  localparam int N_FRAC    = 629;   // 0.25 + 1/625
  localparam int NTSC_INT  = 227;
  localparam int NTSC_FRAC = 1250;  // 0.5
  localparam int M_INT     = 227;
  localparam int M_FRAC    = 625;   // 0.25
  localparam int SEC_INT   = 282;
  localparam int SEC_FRAC  = 0;

endpackage

// File: rtl/sc_ratio_sel.sv
module sc_ratio_sel
  import sc_div_pkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12
) (
  input  logic [2:0]        std_sel,
  output logic [INT_W-1:0]  int_part,
  output logic [FRAC_W-1:0] frac_part
);

  always_comb begin
    int_part  = INT_W'(BG_INT);
    frac_part = FRAC_W'(BG_FRAC);
    case (std_sel)
      STD_PAL_N: begin
        int_part  = INT_W'(N_INT);
        frac_part = FRAC_W'(N_FRAC);
      end
      STD_NTSC: begin
        int_part  = INT_W'(NTSC_INT);
        frac_part = FRAC_W'(NTSC_FRAC);
      end
      STD_PAL_M: begin
        int_part  = INT_W'(M_INT);
        frac_part = FRAC_W'(M_FRAC);
      end
      STD_SECAM: begin
        int_part  = INT_W'(SEC_INT);
        frac_part = FRAC_W'(SEC_FRAC);
      end
      default: begin
        int_part  = INT_W'(BG_INT);
        frac_part = FRAC_W'(BG_FRAC);
      end
    endcase
  end

endmodule

// File: rtl/sc_period_gen.sv
module sc_period_gen #(
  parameter int INT_W    = 9,
  parameter int FRAC_W   = 12,
  parameter int FRAC_DEN = 2500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  int_part,
  input  logic [FRAC_W-1:0] frac_part,
  output logic              ref_q
);

  localparam int SUM_W = FRAC_W + 1;

  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] facc;
  logic [SUM_W-1:0]  fsum;
  logic              carry;
  logic [FRAC_W-1:0] fnext;
  logic [INT_W-1:0]  period;
  logic              load;

  assign load = (cnt == '0);

  always_comb begin
    fsum   = {1'b0, facc} + {1'b0, frac_part};
    carry  = (fsum >= SUM_W'(FRAC_DEN));
    fnext  = FRAC_W'(carry ? (fsum - SUM_W'(FRAC_DEN)) : fsum);
    period = int_part + INT_W'(carry);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      facc  <= '0;
      ref_q <= 1'b0;
    end else begin
      ref_q <= load;
      if (load) begin
        cnt  <= period - INT_W'(1);
        facc <= fnext;
      end else begin
        cnt  <= cnt - INT_W'(1);
      end
    end
  end

  AST_FRAC_RANGE: assert property (@(posedge clk) disable iff (rst)
    facc < FRAC_W'(FRAC_DEN)); // R2

  AST_REF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ref_q |=> !ref_q); // R5

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !$isunknown(cnt)) |=> !ref_q); // R4

endmodule

// File: rtl/sc_phase_cmp.sv
module sc_phase_cmp (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic line_in,
  output logic up,
  output logic dn
);

  logic up_n;
  logic dn_n;

  always_comb begin
    up_n = up | ref_in;
    dn_n = dn | line_in;
    if (up_n && dn_n) begin
      up_n = 1'b0;
      dn_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_n;
      dn <= dn_n;
    end
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(up && dn)); // R10

  AST_UP_SET: assert property (@(posedge clk) disable iff (rst)
    (ref_in && !line_in && !dn) |=> up); // R6

  AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up && !line_in) |=> up); // R6

  AST_DN_SET: assert property (@(posedge clk) disable iff (rst)
    (line_in && !ref_in && !up) |=> dn); // R7

  AST_UP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (up && line_in) |=> (!up && !dn)); // R8

  AST_DN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dn && ref_in) |=> (!up && !dn)); // R8

  AST_COINCIDE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ref_in && line_in && !up && !dn) |=> (!up && !dn)); // R9

endmodule

// File: rtl/sc_line_divider.sv
module sc_line_divider #(
  parameter int INT_W    = 9,
  parameter int FRAC_W   = 12,
  parameter int FRAC_DEN = sc_div_pkg::FRAC_DEN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] std_sel,
  input  logic       line_pulse,
  output logic       ref_pulse,
  output logic       pd_up,
  output logic       pd_dn
);

  logic [INT_W-1:0]  int_part;
  logic [FRAC_W-1:0] frac_part;
  logic              ref_q;

  sc_ratio_sel #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W)
  ) u_ratio (
    .std_sel  (std_sel),
    .int_part (int_part),
    .frac_part(frac_part)
  );

  sc_period_gen #(
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .FRAC_DEN(FRAC_DEN)
  ) u_period (
    .clk      (clk),
    .rst      (rst),
    .int_part (int_part),
    .frac_part(frac_part),
    .ref_q    (ref_q)
  );

  sc_phase_cmp u_cmp (
    .clk    (clk),
    .rst    (rst),
    .ref_in (ref_q),
    .line_in(line_pulse),
    .up     (pd_up),
    .dn     (pd_dn)
  );

  assign ref_pulse = ref_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!ref_pulse && !pd_up && !pd_dn)); // R1

endmodule

// File: tb/sc_line_divider_tb.sv
module sc_line_divider_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int DEN        = 2500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] std_sel = 3'd0;
  logic       line_pulse = 1'b0;
  logic       ref_pulse, pd_up, pd_dn;

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  mup, mdn, prev_ref, prev_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_line_divider u_dut (
    .clk(clk), .rst(rst), .std_sel(std_sel), .line_pulse(line_pulse),
    .ref_pulse(ref_pulse), .pd_up(pd_up), .pd_dn(pd_dn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    line_pulse = 1'b0;
    repeat (3) @(negedge clk);
    check(ref_pulse == 0 && pd_up == 0 && pd_dn == 0, "R1", {ref_pulse, pd_up, pd_dn}, 0);
    rst = 1'b0;
    cyc = 0; mup = 0; mdn = 0; prev_ref = 0; prev_line = 0;
  endtask

  // mode 0: free-running lines, 1: coincident, 2: lagging, 3: leading
  task automatic run(input int code, input int ii, input int ff, input int nlines, input int mode);
    longint next_exp = 1;
    int     n = 0;
    int     last_ref = 0;
    bit     old_up, old_dn, exp_ref, ln;
    std_sel = 3'(code);
    do_reset();
    while (n < nlines) begin
      @(negedge clk);
      cyc++;
      old_up = mup; old_dn = mdn;
      mup = old_up | prev_ref;
      mdn = old_dn | prev_line;
      if (mup && mdn) begin mup = 0; mdn = 0; end
      if (prev_ref && prev_line && !old_up && !old_dn)
        check(!pd_up && !pd_dn, "R9", {pd_up, pd_dn}, 0);
      else if ((old_up && prev_line) || (old_dn && prev_ref))
        check(!pd_up && !pd_dn, "R8", {pd_up, pd_dn}, 0);
      else begin
        check(pd_up == mup, "R6", pd_up, mup);
        check(pd_dn == mdn, "R7", pd_dn, mdn);
      end
      check(!(pd_up && pd_dn), "R10", {pd_up, pd_dn}, 1);
      exp_ref = (cyc == next_exp);
      if (code == 0 && n == 0) check(ref_pulse == exp_ref, "R1", ref_pulse, exp_ref);
      else check(ref_pulse == exp_ref, (code > 4) ? "R3" : "R2", ref_pulse, exp_ref);
      if (ref_pulse && prev_ref) check(0, "R5", 1, 0);
      if (exp_ref) begin
        n++;
        last_ref = cyc;
        next_exp = 1 + longint'(n) * ii + (longint'(n) * ff) / DEN;
      end
      case (mode)
        0: ln = (cyc % 241 == 17);
        1: ln = exp_ref;
        2: ln = (cyc == last_ref + 5);
        default: ln = (longint'(cyc) == next_exp - 7);
      endcase
      prev_ref  = ref_pulse;
      prev_line = ln;
      line_pulse = ln;
    end
    line_pulse = 1'b0;
  endtask

  // R4: standard change in mid-period
  task automatic std_change();
    int refs[$];
    std_sel = 3'd0;
    do_reset();
    while (refs.size() < 5) begin
      @(negedge clk);
      cyc++;
      if (ref_pulse) refs.push_back(cyc);
      if (refs.size() == 2 && cyc == refs[1] + 100) std_sel = 3'd3;
    end
    check(refs[2] - refs[1] inside {283, 284}, "R4", refs[2] - refs[1], 283);
    check(refs[3] - refs[2] inside {227, 228}, "R4", refs[3] - refs[2], 227);
    check(refs[4] - refs[3] inside {227, 228}, "R4", refs[4] - refs[3], 227);
  endtask

  initial begin
    run(0, 283, 1879, 30, 0);
    run(0, 283, 1879, 30, 1);
    run(0, 283, 1879, 30, 2);
    run(0, 283, 1879, 30, 3);
    run(1, 229, 629, 20, 0);   // R3 PAL N
    run(2, 227, 1250, 20, 1);  // R3 NTSC
    run(3, 227, 625, 20, 2);   // R3 PAL M
    run(4, 282, 0, 20, 3);     // R3 SECAM
    run(7, 283, 1879, 10, 0);  // R3 alias code
    run(5, 283, 1879, 10, 1);  // R3 alias code
    std_change();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual %0d cycles expected fewer than %0d", WATCHDOG, WATCHDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule